// File: doc/BRIEF.md
# Segmented 8-bit Multi-cycle Processor Core

This block is a small byte-oriented processor that runs programs from an external synchronous byte memory of 4 KiB. Each instruction is one or two bytes long. There are eight operations: near and far jump, register move, memory load and store, add, xor, compare, conditional jump on equality, and halt. It holds four general registers and two segment registers. The instruction set also reaches the two segment registers as index 4 (code segment) and index 5 (data segment). Every physical address is a segment value times 16 plus an 8-bit offset, kept to 12 bits. Fetches use the code segment and memory moves use the data segment.

The core steps through a small state machine. It fetches the first byte, then decodes it and, when the instruction needs one, fetches a second byte. It then executes, and a load takes one extra state. The memory returns read data one cycle after an address is presented, and a write takes effect at the edge where the write enable is high. The register slots, the instruction pointer, the flags and a sticky halted/fault pair are brought out so that a test environment can observe the machine.

Top module: `seg8_core`

## Requirements
- R1: First instruction byte: opcode in bits 7..5 (0 jmp, 1 movr, 2 movm, 3 add, 4 xor, 5 cmp, 6 jmpe, 7 hlt), mode in bit 4, first register index in bits 3..0. The instruction is one byte for jmp/jmpe in mode 0 and for hlt in either mode; all other forms fetch a second byte, which is a register index in mode 0 and an immediate or segment in mode 1 (movm uses a register in both modes).
- R2: While reset is held, ip, r0..r3, the code segment and the flags read 0, the data segment reads 0x10, and halted and fault are low.
- R3: A physical address is (segment * 16 + offset) mod 4096. Fetches use the code segment with ip, and memory moves use the data segment.
- R4: ip advances by one per fetched byte and wraps modulo 256 inside the current code segment, so it never carries into the segment.
- R5: movr copies a register (mode 0) or loads the immediate (mode 1). Indices 4 and 5 write the code and data segments.
- R6: add wraps modulo 256. xor is bitwise. Both take a register (mode 0) or an immediate (mode 1) as the second operand.
- R7: cmp sets the flags to 0x00 when the operands are equal, to 0xFF when the first is lower (unsigned) and to 0x01 when it is higher. No other flag value ever appears.
- R8: jmp mode 0 loads ip from the named register. jmp mode 1 loads the code segment from the second byte and ip from the named register.
- R9: jmpe acts as jmp of the same mode only when the flags are 0x00; otherwise execution continues with the next instruction.
- R10: movm mode 0 loads r1 from [ds:r2]. movm mode 1 stores r2 to [ds:r1].
- R11: hlt raises halted, which stays high until reset. After that, ip no longer moves and no memory write occurs.
- R12: On any opcode other than hlt, a register index above 5 (the first index, or the second byte where it names a register) raises a sticky fault and halts. hlt with any index does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Byte address to memory |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Store enable |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| halted | output | 1 | Sticky halt indication |
| fault | output | 1 | Sticky bad-register-index indication |
| ip_out | output | 8 | Current instruction pointer |
| flags_out | output | 8 | Flags register |
| reg_state | output | 48 | Register slots, slot i at bits [8i+7:8i] (slot 4 code segment, slot 5 data segment) |

## Verification
The bench builds the core with its default parameters: 8-bit data, a 4-bit segment shift, six register slots and a data segment reset value of 0x10. With these values the whole 4 KiB space is reachable. That means a far jump into segment 1 near offset 0xFE can show that ip wraps inside the segment rather than carrying into address 0x110. It also means a store through two different data-segment values lands at two distinct physical locations. A vector table covers the arithmetic and compare outcomes. Directed programs cover the jumps, conditional branching, loads and stores, halting and faults.

// File: rtl/seg8_pkg.sv
// Shared opcode and state encodings for the segmented 8-bit core.
// Assumes the opcode field is 3 bits wide; all data widths live in the modules.
package seg8_pkg;

    typedef enum logic [2:0] {
        OP_JMP  = 3'd0,
        OP_MOVR = 3'd1,
        OP_MOVM = 3'd2,
        OP_ADD  = 3'd3,
        OP_XOR  = 3'd4,
        OP_CMP  = 3'd5,
        OP_JMPE = 3'd6,
        OP_HLT  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_LOAD   = 3'd3,
        ST_STOP   = 3'd4
    } state_e;

endpackage

// File: rtl/seg8_regs.sv
// Register slots of the core: general registers plus two segment registers.
// One write port and two combinational read ports. An index outside the
// slot range reads as zero and never writes. Slot DS_IDX resets to DS_RESET.
module seg8_regs #(
    parameter int unsigned     DW       = 8,
    parameter int unsigned     NREG     = 6,
    parameter int unsigned     IW       = 4,
    parameter int unsigned     DS_IDX   = 5,
    parameter logic [DW-1:0]   DS_RESET = 8'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IW-1:0]       widx,
    input  logic [DW-1:0]       wdata,
    input  logic [IW-1:0]       ridx_a,
    input  logic [IW-1:0]       ridx_b,
    output logic [DW-1:0]       rdata_a,
    output logic [DW-1:0]       rdata_b,
    output logic [NREG*DW-1:0]  all_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam logic [DW-1:0] RST_VAL = (g == DS_IDX) ? DS_RESET : '0;
        logic [DW-1:0] q;
        // Hold one slot; load it when the write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RST_VAL;
            else if (we && widx == IW'(g))
                q <= wdata;
        end
        assign all_o[g*DW +: DW] = q;
    end

    // Select the two read operands from the packed slot vector.
    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 0; i < NREG; i++) begin
            if (ridx_a == IW'(i)) rdata_a = all_o[i*DW +: DW];
            if (ridx_b == IW'(i)) rdata_b = all_o[i*DW +: DW];
        end
    end

endmodule

// File: rtl/seg8_alu.sv
// Combinational data path: move, add, xor and the three-valued compare.
// Assumes unsigned operands; the result is only used for move/add/xor.
module seg8_alu
    import seg8_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  op_e            op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  res,
    output logic [DW-1:0]  cmp_flags
);

    // Pick the result for the operation; moves pass b through.
    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_XOR:  res = a ^ b;
            default: res = b;
        endcase
    end

    // Encode equal as zero, lower as all ones, higher as one.
    always_comb begin
        if (a == b)
            cmp_flags = '0;
        else if (a < b)
            cmp_flags = '1;
        else
            cmp_flags = DW'(1);
    end

endmodule

// File: rtl/seg8_core.sv
// Top of the segmented 8-bit multi-cycle core. Sequences fetch, decode,
// execute and load states against a synchronous memory with one cycle of
// read latency. Addresses are segment*16 + offset, kept to AW bits.
// Assumes DW + SEG_SH >= AW so the shifted segment covers the memory.
module seg8_core
    import seg8_pkg::*;
#(
    parameter int unsigned   DW       = 8,
    parameter int unsigned   AW       = 12,
    parameter int unsigned   SEG_SH   = 4,
    parameter int unsigned   NREG     = 6,
    parameter int unsigned   CS_IDX   = 4,
    parameter int unsigned   DS_IDX   = 5,
    parameter logic [DW-1:0] DS_RESET = 8'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    output logic                mem_we,
    input  logic [DW-1:0]       mem_rdata,
    output logic                halted,
    output logic                fault,
    output logic [DW-1:0]       ip_out,
    output logic [DW-1:0]       flags_out,
    output logic [NREG*DW-1:0]  reg_state
);

    localparam int unsigned   IW   = 4;
    localparam int unsigned   SUMW = DW + SEG_SH;
    localparam logic [DW-1:0] LAST = DW'(NREG - 1);

    state_e        state;
    logic [DW-1:0] ir;
    logic [DW-1:0] ip;
    logic [DW-1:0] flags_q;
    logic          fault_q;

    op_e           op;
    logic          md;
    logic [IW-1:0] ra;
    op_e           dop;
    logic [DW-1:0] va, vb, alu_res, alu_flg;
    logic [DW-1:0] cs_val, ds_val;
    logic          op2_is_reg, bad_op2, taken;
    logic          reg_we;
    logic [IW-1:0] reg_widx;
    logic [DW-1:0] reg_wdata;

    assign op  = op_e'(ir[7:5]);
    assign md  = ir[4];
    assign ra  = ir[IW-1:0];
    assign dop = op_e'(mem_rdata[7:5]);

    assign cs_val = reg_state[CS_IDX*DW +: DW];
    assign ds_val = reg_state[DS_IDX*DW +: DW];

    seg8_regs #(
        .DW(DW), .NREG(NREG), .IW(IW), .DS_IDX(DS_IDX), .DS_RESET(DS_RESET)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .we(reg_we), .widx(reg_widx), .wdata(reg_wdata),
        .ridx_a(ra), .ridx_b(mem_rdata[IW-1:0]),
        .rdata_a(va), .rdata_b(vb),
        .all_o(reg_state)
    );

    seg8_alu #(.DW(DW)) i_alu (
        .op(op), .a(va), .b(md ? mem_rdata : vb),
        .res(alu_res), .cmp_flags(alu_flg)
    );

    // Form a physical address from a segment and an offset.
    function automatic logic [AW-1:0] phys(input logic [DW-1:0] seg,
                                           input logic [DW-1:0] off);
        logic [SUMW-1:0] s;
        s = {seg, {SEG_SH{1'b0}}} + SUMW'(off);
        return AW'(s);
    endfunction

    // Classify the second byte and the branch condition during execute.
    always_comb begin
        op2_is_reg = (op == OP_MOVM) ||
                     (!md && (op == OP_MOVR || op == OP_ADD ||
                              op == OP_XOR  || op == OP_CMP));
        bad_op2    = op2_is_reg && (mem_rdata > LAST);
        taken      = (op == OP_JMP) || (op == OP_JMPE && flags_q == '0);
    end

    // Drive the memory port: code fetch by default, data access for movm.
    always_comb begin
        mem_addr  = phys(cs_val, ip);
        mem_we    = 1'b0;
        mem_wdata = vb;
        if (state == ST_EXEC && op == OP_MOVM && !bad_op2) begin
            mem_addr = phys(ds_val, md ? va : vb);
            mem_we   = md;
        end
    end

    // Choose the register write for this cycle.
    always_comb begin
        reg_we    = 1'b0;
        reg_widx  = ra;
        reg_wdata = alu_res;
        if (state == ST_EXEC && !bad_op2) begin
            unique case (op)
                OP_MOVR, OP_ADD, OP_XOR: reg_we = 1'b1;
                OP_JMP, OP_JMPE: begin
                    reg_we    = md && taken;
                    reg_widx  = IW'(CS_IDX);
                    reg_wdata = mem_rdata;
                end
                default: reg_we = 1'b0;
            endcase
        end else if (state == ST_LOAD) begin
            reg_we    = 1'b1;
            reg_wdata = mem_rdata;
        end
    end

    // Sequence the states and update ip, flags and the fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FETCH;
            ir      <= '0;
            ip      <= '0;
            flags_q <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ip    <= ip + DW'(1);
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    ir <= mem_rdata;
                    if (dop == OP_HLT) begin
                        state <= ST_STOP;
                    end else if (mem_rdata[IW-1:0] > LAST[IW-1:0]) begin
                        fault_q <= 1'b1;
                        state   <= ST_STOP;
                    end else begin
                        if (!((dop == OP_JMP || dop == OP_JMPE) && !mem_rdata[4]))
                            ip <= ip + DW'(1);
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (bad_op2) begin
                        fault_q <= 1'b1;
                        state   <= ST_STOP;
                    end else begin
                        state <= ST_FETCH;
                        if (op == OP_CMP)
                            flags_q <= alu_flg;
                        if ((op == OP_JMP || op == OP_JMPE) && taken)
                            ip <= (md && ra == IW'(CS_IDX)) ? mem_rdata : va;
                        if (op == OP_MOVM && !md)
                            state <= ST_LOAD;
                    end
                end
                ST_LOAD: state <= ST_FETCH;
                default: state <= ST_STOP;
            endcase
        end
    end

    assign halted    = (state == ST_STOP);
    assign fault     = fault_q;
    assign ip_out    = ip;
    assign flags_out = flags_q;

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_no_store_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
    assert_flags_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out == '0) || (flags_out == DW'(1)) || (flags_out == '1));
    assert_fault_halts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> halted);
    assert_ip_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (ip == $past(ip) + DW'(1)));
    assert_flags_only_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_EXEC && op == OP_CMP) |=> $stable(flags_out));

endmodule

// File: tb/test_seg8_core.sv
module test_seg8_core;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT  = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic        halted, fault;
    logic [7:0]  ip_out, flags_out;
    logic [47:0] reg_state;

    logic [7:0]  mem [4096];
    logic        tb_clr = 1'b0;
    logic        tb_wr  = 1'b0;
    logic [11:0] tb_a   = '0;
    logic [7:0]  tb_d   = '0;
    int          n_total = 0;
    int          n_fail  = 0;
    int          stores_after_halt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg8_core i_seg8_core (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata),
        .halted(halted), .fault(fault),
        .ip_out(ip_out), .flags_out(flags_out), .reg_state(reg_state)
    );

    // Synchronous byte memory with one cycle read latency plus bench load.
    always @(posedge clk) begin
        if (tb_clr) begin
            for (int k = 0; k < 4096; k++) mem[k] <= 8'h00;
        end else if (tb_wr) begin
            mem[tb_a] <= tb_d;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
        if (halted && mem_we) stores_after_halt <= stores_after_halt + 1;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rg(input int i);
        return reg_state[i*8 +: 8];
    endfunction

    task automatic clear_and_hold();
        @(negedge clk);
        rst_n  = 1'b0;
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
    endtask

    task automatic put(input logic [11:0] a, input logic [7:0] d);
        tb_a = a; tb_d = d; tb_wr = 1'b1;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic run_to_halt();
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < RUN_LIMIT && !halted; c++) @(negedge clk);
    endtask

    typedef struct packed {
        logic [47:0] code;
        logic [7:0]  exp_r0;
        logic [7:0]  exp_fl;
    } vec_t;

    // Three two-byte instructions each, followed by hlt.
    localparam vec_t VECS [5] = '{
        '{48'h30_5A_70_B0_B0_0A, 8'h0A, 8'h00},   // add wraps, cmp equal
        '{48'h31_33_30_0F_80_01, 8'h3C, 8'h00},   // xor register form
        '{48'h30_10_B0_20_60_00, 8'h20, 8'hFF},   // cmp lower, add r0,r0
        '{48'h30_FF_B0_01_90_F0, 8'h0F, 8'h01},   // cmp higher, xor imm
        '{48'h32_77_20_02_A0_02, 8'h77, 8'h00}    // movr reg form, cmp reg
    };

    initial begin
        logic [7:0] ip_hold;

        // R2: state under reset
        clear_and_hold();
        repeat (2) @(negedge clk);
        chk("R2 ip", {8'h0, ip_out}, 16'h0000);
        chk("R2 flags", {8'h0, flags_out}, 16'h0000);
        chk("R2 regs low", reg_state[15:0], 16'h0000);
        chk("R2 regs r2..cs", reg_state[39:16], 24'h0);
        chk("R2 ds", {8'h0, rg(5)}, 16'h0010);
        chk("R2 halted/fault", {14'h0, halted, fault}, 16'h0000);

        // R1 R5 R6 R7: vector table
        foreach (VECS[v]) begin
            clear_and_hold();
            for (int k = 0; k < 6; k++) put(12'(k), VECS[v].code[(5-k)*8 +: 8]);
            put(12'd6, 8'hE0);
            run_to_halt();
            chk("R6 R5 r0 result", {8'h0, rg(0)}, {8'h0, VECS[v].exp_r0});
            chk("R7 flags", {8'h0, flags_out}, {8'h0, VECS[v].exp_fl});
        end

        // R10 R3 R5: store and load through two data segment values
        clear_and_hold();
        put(12'h000, 8'h31); put(12'h001, 8'h05);   // movr r1,#05
        put(12'h002, 8'h32); put(12'h003, 8'hC3);   // movr r2,#C3
        put(12'h004, 8'h51); put(12'h005, 8'h02);   // movm [ds:r1],r2
        put(12'h006, 8'h43); put(12'h007, 8'h01);   // movm r3,[ds:r1]
        put(12'h008, 8'h35); put(12'h009, 8'h20);   // movr ds,#20
        put(12'h00A, 8'h51); put(12'h00B, 8'h02);   // movm [ds:r1],r2
        put(12'h00C, 8'hE0);
        run_to_halt();
        chk("R10 store at 0x105", {8'h0, mem[12'h105]}, 16'h00C3);
        chk("R10 load into r3", {8'h0, rg(3)}, 16'h00C3);
        chk("R5 ds written", {8'h0, rg(5)}, 16'h0020);
        chk("R3 store at 0x205", {8'h0, mem[12'h205]}, 16'h00C3);

        // R8 R1 R11: far jump then halt, then stickiness
        clear_and_hold();
        put(12'h000, 8'h30); put(12'h001, 8'h08);   // movr r0,#08
        put(12'h002, 8'h10); put(12'h003, 8'h03);   // jmp far 03:r0
        put(12'h038, 8'h31); put(12'h039, 8'h99);   // movr r1,#99
        put(12'h03A, 8'hE0);
        run_to_halt();
        chk("R8 cs loaded", {8'h0, rg(4)}, 16'h0003);
        chk("R8 target executed", {8'h0, rg(1)}, 16'h0099);
        chk("R1 hlt one byte ip", {8'h0, ip_out}, 16'h000B);
        ip_hold = ip_out;
        repeat (20) @(negedge clk);
        chk("R11 ip frozen", {8'h0, ip_out}, {8'h0, ip_hold});
        chk("R11 halted sticky", {15'h0, halted}, 16'h0001);
        chk("R11 no store after halt", 16'(stores_after_halt), 16'h0000);

        // R9 R1: jmpe not taken then taken (one-byte form)
        clear_and_hold();
        put(12'h000, 8'h30); put(12'h001, 8'h01);   // movr r0,#01
        put(12'h002, 8'hB0); put(12'h003, 8'h02);   // cmp r0,#02 -> FF
        put(12'h004, 8'h31); put(12'h005, 8'h10);   // movr r1,#10
        put(12'h006, 8'hC1);                        // jmpe r1 (not taken)
        put(12'h007, 8'h32); put(12'h008, 8'h11);   // movr r2,#11
        put(12'h009, 8'hA0); put(12'h00A, 8'h00);   // cmp r0,r0 -> 0
        put(12'h00B, 8'hC1);                        // jmpe r1 (taken)
        put(12'h00C, 8'h32); put(12'h00D, 8'hEE);   // skipped
        put(12'h00E, 8'hE0);
        put(12'h010, 8'h33); put(12'h011, 8'h44);   // movr r3,#44
        put(12'h012, 8'hE0);
        run_to_halt();
        chk("R9 fallthrough ran", {8'h0, rg(2)}, 16'h0011);
        chk("R9 taken target ran", {8'h0, rg(3)}, 16'h0044);

        // R4 R3: ip wraps inside code segment 1
        clear_and_hold();
        put(12'h000, 8'h30); put(12'h001, 8'hFE);   // movr r0,#FE
        put(12'h002, 8'h10); put(12'h003, 8'h01);   // jmp far 01:r0
        put(12'h10E, 8'h30); put(12'h10F, 8'h66);   // movr r0,#66
        put(12'h010, 8'hE0);                        // 01:00
        put(12'h110, 8'h30); put(12'h111, 8'h77);   // wrong if carried
        put(12'h112, 8'hE0);
        run_to_halt();
        chk("R4 r0 after wrap", {8'h0, rg(0)}, 16'h0066);
        chk("R4 halted at wrap target", {15'h0, halted}, 16'h0001);
        chk("R4 ip after wrap", {8'h0, ip_out}, 16'h0001);

        // R12: bad first index, bad second index, hlt with high index
        clear_and_hold();
        put(12'h000, 8'h27);                        // movr r7,...
        run_to_halt();
        chk("R12 fault first index", {14'h0, fault, halted}, 16'h0003);
        clear_and_hold();
        put(12'h000, 8'h60); put(12'h001, 8'h09);   // add r0,r9
        run_to_halt();
        chk("R12 fault second index", {14'h0, fault, halted}, 16'h0003);
        clear_and_hold();
        put(12'h000, 8'hEF);                        // hlt with index 15
        run_to_halt();
        chk("R12 hlt no fault", {14'h0, fault, halted}, 16'h0001);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule